// File: doc/BRIEF.md
# I2C Slave Voltage-Code Register

This block is an I2C slave with a single 8-bit control register. The low four bits of that register drive the reference-voltage code of a downstream DAC. SCL and SDA enter from the pads as plain levels. Each line is synchronised to a fast system clock. START, repeated START, STOP and the SCL edges are then detected on the synchronised copies.

A master addresses the block with a fixed 7-bit device address. In a write, every data byte that follows is acknowledged. Each byte is committed to the register on the SCL rising edge of its acknowledge clock, so the new code reaches the DAC while the ninth clock is still high and before any STOP. In a read, the slave shifts the whole register out MSB first. A master ACK makes it send the same byte again. A master NACK makes it release the bus.

SDA leaves the block only as a pull-low enable. It never drives a logic 1, so several devices can share the line as a wired-AND.

Top module: `i2c_vcode_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register returns to `RESET_VAL` (default 8'h00), so `vcode` shows 4'h0 and `sda_pull` is 0.
- R2: After a START, when the first byte holds `DEV_ADDR` (default 7'h4C) in bits 7..1, MSB first, the slave pulls SDA low for the whole ninth clock. Bit 0 of that byte selects the direction: 0 is write, 1 is read.
- R3: When the address does not match, the slave never pulls SDA. Every later byte is ignored until the next START: no ACK is given and `vcode` does not change.
- R4: In a write, every received data byte is acknowledged by pulling SDA low during its ninth clock.
- R5: A written byte reaches the register on the SCL rising edge of its acknowledge clock. `vcode` still holds the old value before that edge and the new value while SCL is still high, before any STOP.
- R6: Any number of data bytes may follow one address. Each one commits in turn, and the last one remains.
- R7: `vcode` always equals bits 3..0 of the register.
- R8: A read returns all eight register bits, MSB first, so the upper four bits read back exactly as they were written.
- R9: After a read byte, a master ACK makes the slave send the same register byte again. A master NACK makes it release SDA for good until the next START.
- R10: A START or repeated START in the middle of a byte restarts address framing. A STOP in the middle of a byte ends the transfer without a commit.
- R11: `sda_pull` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad (the wired-AND result) |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases the line |
| vcode | output | CODE_W (4) | Reference-voltage code for the DAC |

## Verification
Four properties are checked on every cycle:
- `sda_pull` never changes while synchronised SCL is high.
- The slave stays quiet in every state where it only listens.
- `vcode` changes only on the cycle after an SCL rise in a write-acknowledge slot.
- The committed value is the byte just received.

Only the bench's scenarios can show the rest:
- The exact bytes read back.
- Repeat-on-ACK.
- The no-ACK behaviour on an address mismatch.
- The effect of a START or STOP that cuts a byte short.

The bench checks these through the shared SDA line and `vcode`.

// File: rtl/i2c_vc_pkg.sv
package i2c_vc_pkg;

    localparam int REG_W = 8;
    localparam int BIT_CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } bus_st_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(input logic [REG_W-1:0] b, input logic [6:0] a);
        return b[REG_W-1:1] == a;
    endfunction

endpackage

// File: rtl/i2c_vc_sync.sv
module i2c_vc_sync
    import i2c_vc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
        end else begin
            prev <= synced;
        end
    end

    always_comb begin
        ev.scl      = synced[1];
        ev.sda      = synced[0];
        ev.scl_rise = synced[1] & ~prev[1];
        ev.scl_fall = ~synced[1] & prev[1];
        ev.start    = synced[1] & prev[1] & prev[0] & ~synced[0];
        ev.stop     = synced[1] & prev[1] & ~prev[0] & synced[0];
    end

endmodule

// File: rtl/i2c_vc_fsm.sv
module i2c_vc_fsm
    import i2c_vc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  logic [REG_W-1:0] reg_q,
    output bus_st_e          st,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data
);

    logic [BIT_CNT_W-1:0] cnt;
    logic [REG_W-1:0]     shreg;
    logic                 rnw;
    logic                 mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            rnw   <= 1'b0;
            mack  <= 1'b0;
        end else if (ev.start) begin
            st  <= ST_ADDR;
            cnt <= '0;
        end else if (ev.stop) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_ADDR, ST_WDATA: begin
                    if (ev.scl_rise) begin
                        shreg <= {shreg[REG_W-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (ev.scl_fall && cnt == BIT_CNT_W'(REG_W)) begin
                        cnt <= '0;
                        if (st == ST_WDATA) begin
                            st <= ST_WACK;
                        end else if (addr_hit(shreg, DEV_ADDR)) begin
                            st  <= ST_AACK;
                            rnw <= shreg[0];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.scl_fall) begin
                        if (rnw) begin
                            st    <= ST_RDATA;
                            shreg <= reg_q;
                        end else begin
                            st <= ST_WDATA;
                        end
                        cnt <= '0;
                    end
                end
                ST_WACK: begin
                    if (ev.scl_fall) begin
                        st  <= ST_WDATA;
                        cnt <= '0;
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        shreg <= {shreg[REG_W-2:0], 1'b0};
                        if (cnt == BIT_CNT_W'(REG_W - 1)) begin
                            st  <= ST_RACK;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack) begin
                            st    <= ST_RDATA;
                            shreg <= reg_q;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_pull = (st == ST_AACK) || (st == ST_WACK) ||
                   ((st == ST_RDATA) && !shreg[REG_W-1]);
        wr_en    = (st == ST_WACK) && ev.scl_rise;
        wr_data  = shreg;
    end

endmodule

// File: rtl/i2c_vc_reg.sv
module i2c_vc_reg
    import i2c_vc_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] reg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= RESET_VAL;
        end else if (wr_en) begin
            reg_q <= wr_data;
        end
    end

endmodule

// File: rtl/i2c_vcode_reg.sv
module i2c_vcode_reg
    import i2c_vc_pkg::*;
#(
    parameter logic [6:0]       DEV_ADDR    = 7'h4C,
    parameter logic [REG_W-1:0] RESET_VAL   = 8'h00,
    parameter int               SYNC_STAGES = 2,
    parameter int               CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [CODE_W-1:0] vcode
);

    line_ev_t         ev;
    bus_st_e          st;
    logic             wr_en;
    logic [REG_W-1:0] wr_data;
    logic [REG_W-1:0] reg_q;

    i2c_vc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_vc_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .reg_q    (reg_q),
        .st       (st),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    i2c_vc_reg #(.RESET_VAL(RESET_VAL)) reg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .reg_q   (reg_q)
    );

    assign vcode = reg_q[CODE_W-1:0];

endmodule

// File: rtl/i2c_vc_chk.sv
module i2c_vc_chk
    import i2c_vc_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input line_ev_t          ev,
    input bus_st_e           st,
    input logic              sda_pull,
    input logic [REG_W-1:0]  wr_data,
    input logic [CODE_W-1:0] vcode
);

    a_r11_pull_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl)) |-> $stable(sda_pull));

    a_r3_listen_states_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE || st == ST_ADDR || st == ST_WDATA || st == ST_RACK) |-> !sda_pull);

    a_r5_code_moves_on_ack_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(vcode) |-> ($past(st) == ST_WACK && $past(ev.scl_rise)));

    a_r7_code_is_received_byte: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WACK && ev.scl_rise) |=> (vcode == $past(wr_data[CODE_W-1:0])));

endmodule

bind i2c_vcode_reg i2c_vc_chk #(.CODE_W(CODE_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .st       (st),
    .sda_pull (sda_pull),
    .wr_data  (wr_data),
    .vcode    (vcode)
);

// File: tb/i2c_vcode_reg_tb_top.sv
`timescale 1ns/1ps
module i2c_vcode_reg_tb_top;

    localparam int Q = 20;
    localparam logic [6:0] ADDR = 7'h4C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [3:0] vcode;
    logic sda_line;

    int n_tests = 0;
    int n_fail = 0;

    assign sda_line = sda_m & ~sda_pull;

    always #2.5 clk = ~clk;

    i2c_vcode_reg dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .vcode    (vcode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack,
                             output logic [3:0] code_pre, output logic [3:0] code_mid);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        code_pre = vcode;
        scl = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        code_mid = vcode;
        tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        logic first;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(Q);
            scl = 1'b1; tick(Q/2);
            first = sda_line;
            tick(Q/2);
            b = {b[6:0], sda_line};
            tick(Q - 1);
            check("R11 line steady while SCL high", int'(sda_line), int'(first));
            tick(1);
            scl = 1'b0; tick(Q);
        end
        sda_m = master_ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic t_reset();
        check("R1 vcode after reset", int'(vcode), 0);
        check("R1 sda_pull after reset", int'(sda_pull), 0);
    endtask

    task automatic t_single_write();
        logic ack; logic [3:0] pre, mid;
        bus_start();
        send_byte({ADDR, 1'b0}, ack, pre, mid);
        check("R2 address ack", int'(ack), 1);
        send_byte(8'hA5, ack, pre, mid);
        check("R4 data ack", int'(ack), 1);
        check("R5 old code before ack rise", int'(pre), 0);
        check("R5 R7 new code during ack high", int'(mid), 5);
        bus_stop();
        check("R7 code after stop", int'(vcode), 5);
    endtask

    task automatic t_multi_write();
        logic ack; logic [3:0] pre, mid;
        bus_start();
        send_byte({ADDR, 1'b0}, ack, pre, mid);
        send_byte(8'h37, ack, pre, mid);
        check("R6 first byte ack", int'(ack), 1);
        check("R6 first byte commits", int'(mid), 7);
        send_byte(8'hC9, ack, pre, mid);
        check("R6 second byte ack", int'(ack), 1);
        check("R6 second byte commits", int'(mid), 9);
        bus_stop();
        check("R6 last byte remains", int'(vcode), 9);
    endtask

    task automatic t_mismatch();
        logic ack; logic [3:0] pre, mid;
        bus_start();
        send_byte({ADDR ^ 7'h01, 1'b0}, ack, pre, mid);
        check("R3 no ack on wrong address", int'(ack), 0);
        send_byte(8'h12, ack, pre, mid);
        check("R3 no ack on ignored data", int'(ack), 0);
        check("R3 code unchanged", int'(mid), 9);
        bus_stop();
        check("R3 code unchanged after stop", int'(vcode), 9);
    endtask

    task automatic t_read();
        logic ack; logic [3:0] pre, mid; logic [7:0] rd;
        bus_start();
        send_byte({ADDR, 1'b1}, ack, pre, mid);
        check("R2 read address ack", int'(ack), 1);
        recv_byte(1'b1, rd);
        check("R8 full register read", int'(rd), 8'hC9);
        recv_byte(1'b0, rd);
        check("R9 repeat after master ack", int'(rd), 8'hC9);
        check("R9 released after nack", int'(sda_pull), 0);
        bus_stop();
    endtask

    task automatic t_framing();
        logic ack; logic [3:0] pre, mid; logic [7:0] rd;
        bus_start();
        send_byte({ADDR, 1'b0}, ack, pre, mid);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_rstart();
        send_byte({ADDR, 1'b0}, ack, pre, mid);
        check("R10 address ack after repeated start", int'(ack), 1);
        send_byte(8'h63, ack, pre, mid);
        check("R10 write after repeated start", int'(mid), 3);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        check("R10 partial byte before stop no commit", int'(vcode), 3);
        bus_start();
        send_byte({ADDR, 1'b1}, ack, pre, mid);
        recv_byte(1'b0, rd);
        check("R10 R8 register intact after aborted byte", int'(rd), 8'h63);
        bus_stop();
    endtask

    initial begin
        #750000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(10);
        rst = 1'b0;
        tick(10);
        t_reset();
        t_single_write();
        t_multi_write();
        t_mismatch();
        t_read();
        t_framing();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule